// File: doc/BRIEF.md
# Program-Counter Trap Capture and Serial Tap Output

This block lets a sequential audio DSP expose internal signal values without adding a data path. Up to eight trap registers each hold a program-counter value. The DSP presents its running program counter and the data word it is working on every cycle. When the counter equals a channel's trap value, that word is copied into the channel's capture register. The 26-bit word is in 3.23 fixed point, and it is saturated to 24 bits when it is copied.

Channels 0 and 1 feed a stereo serial output. This output follows the frame clock and bit clock of the active serial input port, so the three wires together form a normal left-justified stream. Channels 2 to 7 feed a six-channel time-division stream. That stream has its own bit clock, its own frame sync and its own data line, and it runs only when a 2-bit mode field holds 01. The captured words move into the serializers only at a frame boundary, so one frame never mixes old and new samples.

The DSP tap input carries a valid flag and has no ready. The block never applies back-pressure: a beat offered with `dsp_valid` high is taken in that cycle, and the DSP never stalls. The register port is a plain single-cycle write strobe.

Top module: `pct_tap_top`

## Requirements
- R1: After reset, all trap values and capture words are zero, the mode field is 00, and `ser_dout`, `tdm_bclk`, `tdm_fs` and `tdm_dout` are low.
- R2: A write with `reg_wr` high sets a trap value. Address 263 sets channel 0 (left) and 264 sets channel 1 (right). Addresses 268 to 273 set channels 2 to 7 (TDM channels 1 to 6). Writes to any other address, except the mode address, leave every trap unchanged.
- R3: A channel's capture word loads on the clock edge where `dsp_valid` is high and `dsp_pc` equals its trap. It keeps its value when `dsp_valid` is low or the counter does not match.
- R4: The 26-bit word is cut to bits [23:0] when bits [25:23] are all equal. Otherwise it becomes 24'h7FFFFF if bit 25 is 0, or 24'h800000 if bit 25 is 1.
- R5: The stereo output sends the left word while `ser_lrclk` is high and the right word while it is low. Each word is 24 bits, MSB first, followed by zeros. Data changes on the falling edge of `ser_bclk`, and the first bit appears at the bit-clock fall where `ser_lrclk` changes.
- R6: At the start of each left word, both stereo capture words are latched together. A capture made later in that frame first appears in the next frame.
- R7: The mode field is at address 267, bits [1:0]. The TDM outputs run only when it holds 01; any other value holds `tdm_bclk`, `tdm_fs` and `tdm_dout` low.
- R8: A TDM frame is 256 bits, made of eight 32-bit slots. TDM channels 1 to 6 fill slots 0 to 5, each as 24 bits MSB first followed by 8 zeros. Slots 6 and 7 are all zero. Data changes on the falling edge of `tdm_bclk`.
- R9: `tdm_fs` is high for exactly one bit period, the last bit before slot 0 (bit 255 of the previous frame).
- R10: The six TDM capture words are latched together at the frame sync. A capture made during a frame first appears in the next frame.
- R11: `tdm_bclk` has a period of 2×TDM_DIV clock cycles; with the default of 1, that is two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register write address |
| reg_wdata | input | 9 | Register write data (trap value or mode) |
| dsp_valid | input | 1 | DSP tap beat valid; never back-pressured |
| dsp_pc | input | 9 | DSP program counter |
| dsp_word | input | 26 | DSP data word, 3.23 fixed point |
| ser_bclk | input | 1 | Bit clock of the active serial input, synchronous to clk |
| ser_lrclk | input | 1 | Frame clock of the active serial input, synchronous to clk |
| ser_dout | output | 1 | Stereo serial tap data |
| tdm_bclk | output | 1 | TDM bit clock |
| tdm_fs | output | 1 | TDM frame sync |
| tdm_dout | output | 1 | TDM serial data |

## Verification
A wrong trap value, a missed capture or a bad saturation shows up as a wrong 24-bit word in the next full frame after the capture. On the stereo output that is within one frame-clock period. On the TDM output it is at the next frame sync. A broken frame-boundary transfer shows up as a word that changes in the middle of a frame. To catch this, captures are made mid-frame and both that frame and the next are compared. Errors in the TDM counters show up at once, as a moved or widened frame sync or as non-zero bits in the padding and unused slots.

// File: rtl/pct_pkg.sv
package pct_pkg;
  // Register addresses; the channel order follows these addresses.
  localparam int ADDR_STEREO0 = 263;
  localparam int ADDR_MODE    = 267;
  localparam int ADDR_TDM0    = 268;
  localparam logic [1:0] MODE_TDM_ON = 2'b01;
endpackage

// File: rtl/pct_trap_bank.sv
module pct_trap_bank #(
  parameter int PC_W  = 9,
  parameter int IN_W  = 26,
  parameter int OUT_W = 24,
  parameter int N_CH  = 8,
  parameter int AW    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [AW-1:0]               reg_addr,
  input  logic [PC_W-1:0]             reg_wdata,
  input  logic                        dsp_valid,
  input  logic [PC_W-1:0]             dsp_pc,
  input  logic [IN_W-1:0]             dsp_word,
  output logic [N_CH-1:0][OUT_W-1:0]  cap_o
);
  import pct_pkg::*;

  localparam int GW = IN_W - OUT_W + 1;

  logic [GW-1:0]    guard;
  logic [OUT_W-1:0] sat_word;

  // Saturate the 3.23 word to a 24-bit word
  always_comb begin
    guard = dsp_word[IN_W-1 -: GW];
    if ((&guard) || !(|guard))
      sat_word = dsp_word[OUT_W-1:0];
    else if (dsp_word[IN_W-1])
      sat_word = {1'b1, {(OUT_W-1){1'b0}}};
    else
      sat_word = {1'b0, {(OUT_W-1){1'b1}}};
  end

  logic [N_CH-1:0][PC_W-1:0] trap_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [AW-1:0] CH_ADDR =
      (g < 2) ? AW'(ADDR_STEREO0 + g) : AW'(ADDR_TDM0 + g - 2);

    logic hit;
    assign hit = dsp_valid && (dsp_pc == trap_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trap_q[g] <= '0;
        cap_o[g]  <= '0;
      end else begin
        if (reg_wr && reg_addr == CH_ADDR) trap_q[g] <= reg_wdata;
        if (hit) cap_o[g] <= sat_word;
      end
    end

    // R3: no capture without a valid matching beat
    a_r3_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !(dsp_valid && dsp_pc == trap_q[g]) |=> $stable(cap_o[g]));
  end

  // R4: a word whose guard bits agree passes unchanged
  a_r4_in_range_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_pc == trap_q[0] && dsp_word[IN_W-1:OUT_W-1] == '0)
      |=> cap_o[0] == $past(dsp_word[OUT_W-1:0]));
endmodule

// File: rtl/pct_stereo_ser.sv
module pct_stereo_ser #(
  parameter int OUT_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             fclk,
  input  logic [OUT_W-1:0] cap_l,
  input  logic [OUT_W-1:0] cap_r,
  output logic             sdo
);
  logic             sclk_q;
  logic             fclk_seen;
  logic [OUT_W-1:0] sr;
  logic [OUT_W-1:0] pend_r;
  logic [CNT_W-1:0] bcnt;
  logic             fall;

  assign fall = sclk_q && !sclk;
  assign sdo  = sr[OUT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      fclk_seen <= 1'b0;
      sr        <= '0;
      pend_r    <= '0;
      bcnt      <= '0;
    end else begin
      sclk_q <= sclk;
      if (fall) begin
        if (fclk != fclk_seen) begin
          fclk_seen <= fclk;
          bcnt      <= '0;
          if (fclk) begin
            sr     <= cap_l;
            pend_r <= cap_r;
          end else begin
            sr <= pend_r;
          end
        end else begin
          sr <= {sr[OUT_W-2:0], 1'b0};
          if (bcnt != '1) bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  // R5: padding bits after the 24-bit word are zero
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bcnt) >= OUT_W) |-> !sdo);
  // R6: right word is latched only at the start of a left word
  a_r6_right_latch_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pend_r) |-> (fclk_seen && bcnt == '0));
endmodule

// File: rtl/pct_tdm_ser.sv
module pct_tdm_ser #(
  parameter int OUT_W  = 24,
  parameter int N_TCH  = 6,
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int DIV    = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [N_TCH-1:0][OUT_W-1:0] caps,
  output logic                        tbclk,
  output logic                        tfs,
  output logic                        tdo
);
  localparam int FRAME = SLOT_W * SLOTS;
  localparam int BW    = $clog2(FRAME);
  localparam int SIW   = $clog2(SLOTS);
  localparam int PW    = $clog2(SLOT_W);
  localparam int DCW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DCW-1:0]              dcnt;
  logic [BW-1:0]               bitc;
  logic [BW-1:0]               nb;
  logic [SIW-1:0]              slot;
  logic [PW-1:0]               pos;
  logic                        nbit;
  logic [N_TCH-1:0][OUT_W-1:0] hold;

  always_comb begin
    nb   = bitc + 1'b1;
    slot = nb[BW-1 -: SIW];
    pos  = nb[PW-1:0];
    nbit = 1'b0;
    if (int'(slot) < N_TCH && int'(pos) < OUT_W)
      nbit = hold[slot][OUT_W-1-int'(pos)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt  <= '0;
      tbclk <= 1'b0;
      bitc  <= BW'(FRAME - 2);
      tfs   <= 1'b0;
      tdo   <= 1'b0;
      hold  <= '0;
    end else if (!en) begin
      dcnt  <= '0;
      tbclk <= 1'b0;
      bitc  <= BW'(FRAME - 2);
      tfs   <= 1'b0;
      tdo   <= 1'b0;
    end else if (dcnt == DCW'(DIV - 1)) begin
      dcnt  <= '0;
      tbclk <= !tbclk;
      if (tbclk) begin
        bitc <= nb;
        tfs  <= (nb == BW'(FRAME - 1));
        tdo  <= nbit;
        if (nb == BW'(FRAME - 1)) hold <= caps;
      end
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // R7: outputs quiet while disabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tbclk && !tfs && !tdo));
  // R8/R9: frame sync sits in the zero slot 7
  a_r9_fs_in_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tfs |-> !tdo);
  // R10: holding words change only together with frame sync
  a_r10_hold_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold) |-> tfs);
endmodule

// File: rtl/pct_tap_top.sv
module pct_tap_top #(
  parameter int PC_W    = 9,
  parameter int IN_W    = 26,
  parameter int OUT_W   = 24,
  parameter int AW      = 9,
  parameter int TDM_DIV = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [PC_W-1:0] reg_wdata,
  input  logic            dsp_valid,
  input  logic [PC_W-1:0] dsp_pc,
  input  logic [IN_W-1:0] dsp_word,
  input  logic            ser_bclk,
  input  logic            ser_lrclk,
  output logic            ser_dout,
  output logic            tdm_bclk,
  output logic            tdm_fs,
  output logic            tdm_dout
);
  import pct_pkg::*;

  localparam int N_TCH = 6;
  localparam int N_CH  = 2 + N_TCH;

  logic [N_CH-1:0][OUT_W-1:0] cap;
  logic [1:0]                 mode_q;
  logic                       tdm_en;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'b00;
    else if (reg_wr && reg_addr == AW'(ADDR_MODE)) mode_q <= reg_wdata[1:0];
  end
  assign tdm_en = (mode_q == MODE_TDM_ON);

  pct_trap_bank #(.PC_W(PC_W), .IN_W(IN_W), .OUT_W(OUT_W), .N_CH(N_CH), .AW(AW)) i_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dsp_valid(dsp_valid), .dsp_pc(dsp_pc),
    .dsp_word(dsp_word), .cap_o(cap));

  pct_stereo_ser #(.OUT_W(OUT_W)) i_stereo (
    .clk(clk), .rst_n(rst_n), .sclk(ser_bclk), .fclk(ser_lrclk),
    .cap_l(cap[0]), .cap_r(cap[1]), .sdo(ser_dout));

  pct_tdm_ser #(.OUT_W(OUT_W), .N_TCH(N_TCH), .DIV(TDM_DIV)) i_tdm (
    .clk(clk), .rst_n(rst_n), .en(tdm_en), .caps(cap[N_CH-1:2]),
    .tbclk(tdm_bclk), .tfs(tdm_fs), .tdo(tdm_dout));

  // R1: mode field cleared by reset keeps the TDM pins low
  a_r1_reset_mode: assert property (@(posedge clk)
    !rst_n |=> (mode_q == 2'b00));
endmodule

// File: tb/test_pct_tap_top.sv
module test_pct_tap_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic dsp_valid = 1'b0;
  logic [8:0] dsp_pc = '0;
  logic [25:0] dsp_word = '0;
  logic ser_bclk = 1'b1;
  logic ser_lrclk = 1'b0;
  logic ser_dout, tdm_bclk, tdm_fs, tdm_dout;

  int checks = 0;
  int fails = 0;

  always #5 clk = !clk;

  pct_tap_top i_pct_tap_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dsp_valid(dsp_valid), .dsp_pc(dsp_pc),
    .dsp_word(dsp_word), .ser_bclk(ser_bclk), .ser_lrclk(ser_lrclk),
    .ser_dout(ser_dout), .tdm_bclk(tdm_bclk), .tdm_fs(tdm_fs),
    .tdm_dout(tdm_dout));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sat(input logic [25:0] w);
    if (w[25:23] == 3'b000 || w[25:23] == 3'b111) return w[23:0];
    return w[25] ? 24'h800000 : 24'h7FFFFF;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 9'(a); reg_wdata = 9'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic dsp(input int pc, input logic [25:0] w, input logic v);
    @(negedge clk); dsp_valid = v; dsp_pc = 9'(pc); dsp_word = w;
    @(negedge clk); dsp_valid = 1'b0;
  endtask

  // Two stereo frames: {L0,R0,L1,R1}; optional capture at bit chg_at of frame 0
  task automatic st_grab(output logic [127:0] f, input int chg_at,
                         input int cpc, input logic [25:0] cw);
    for (int fr = 0; fr < 2; fr++)
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < 32; b++) begin
          @(negedge clk); ser_bclk = 1'b0;
          if (b == 0) ser_lrclk = (h == 0);
          @(negedge clk);
          @(negedge clk); ser_bclk = 1'b1;
          f[127 - (fr*64 + h*32 + b)] = ser_dout;
          if (fr == 0 && h == 0 && b == chg_at) dsp(cpc, cw, 1'b1);
          @(negedge clk);
        end
  endtask

  // Two TDM frames after a frame sync; fs_bad counts misplaced syncs
  task automatic tdm_grab(output logic [511:0] f, output int fs_bad, input int chg_at,
                          input int cpc, input logic [25:0] cw);
    fs_bad = 0;
    do begin @(posedge tdm_bclk); #1; end while (!tdm_fs);
    for (int i = 0; i < 512; i++) begin
      @(posedge tdm_bclk); #1;
      f[511 - i] = tdm_dout;
      if (tdm_fs !== ((i % 256) == 255)) fs_bad++;
      if (i == chg_at) dsp(cpc, cw, 1'b1);
    end
  endtask

  function automatic logic [255:0] tdm_exp(input logic [5:0][23:0] v);
    logic [255:0] e = '0;
    for (int s = 0; s < 6; s++) e[255 - 32*s -: 32] = {v[s], 8'h00};
    return e;
  endfunction

  task automatic t_reset();
    logic [127:0] f;
    chk("R1 ser_dout", 64'(ser_dout), 0);
    chk("R1 tdm_bclk", 64'(tdm_bclk), 0);
    chk("R1 tdm_fs", 64'(tdm_fs), 0);
    chk("R1 tdm_dout", 64'(tdm_dout), 0);
    st_grab(f, -1, 0, '0);
    chk("R1 stereo words zero", f[127:64], 0);
  endtask

  task automatic t_stereo();
    logic [127:0] f;
    wr(263, 10); wr(264, 11);
    dsp(10, 26'h0123456, 1'b1);
    dsp(11, 26'h3FEDCBA, 1'b1);
    st_grab(f, -1, 0, '0);
    chk("R5 R2 left word", f[127:96], {32'h12345600});
    chk("R5 R2 right word", f[95:64], {32'hFEDCBA00});
  endtask

  task automatic t_sat();
    logic [127:0] f;
    dsp(10, 26'h1000000, 1'b1);
    dsp(11, 26'h2000000, 1'b1);
    st_grab(f, -1, 0, '0);
    chk("R4 positive clip", f[127:96], {sat(26'h1000000), 8'h00});
    chk("R4 negative clip", f[95:64], {sat(26'h2000000), 8'h00});
  endtask

  task automatic t_nocap();
    logic [127:0] f;
    dsp(10, 26'h0000AAA, 1'b0);   // valid low
    dsp(12, 26'h0000BBB, 1'b1);   // no trap at 12
    wr(265, 12); wr(266, 12);      // unmapped addresses
    dsp(12, 26'h0000CCC, 1'b1);
    st_grab(f, -1, 0, '0);
    chk("R3 left kept", f[127:96], {sat(26'h1000000), 8'h00});
    chk("R2 R3 right kept", f[95:64], {sat(26'h2000000), 8'h00});
  endtask

  task automatic t_stereo_boundary();
    logic [127:0] f;
    dsp(10, 26'h0111111, 1'b1);
    dsp(11, 26'h0222222, 1'b1);
    st_grab(f, 5, 11, 26'h0333333);
    chk("R6 right old in frame", f[95:64], 32'h22222200);
    chk("R6 right new next frame", f[31:0], 32'h33333300);
    chk("R6 left next frame", f[63:32], 32'h11111100);
  endtask

  task automatic t_tdm_off();
    int seen = 0;
    wr(267, 2);
    repeat (600) begin
      @(negedge clk);
      if (tdm_bclk || tdm_fs || tdm_dout) seen++;
    end
    chk("R7 mode 10 keeps TDM low", 64'(seen), 0);
  endtask

  task automatic t_tdm();
    logic [511:0] f;
    logic [5:0][23:0] v;
    int fsb, t0, t1;
    for (int c = 0; c < 6; c++) begin
      v[c] = sat(26'(26'h0100001 * (c + 1) + 26'h0050000));
      wr(268 + c, 20 + c);
      dsp(20 + c, 26'(26'h0100001 * (c + 1) + 26'h0050000), 1'b1);
    end
    v[5] = sat(26'h3A00000);
    dsp(25, 26'h3A00000, 1'b1);
    wr(267, 1);
    @(posedge tdm_bclk); t0 = $time;
    @(posedge tdm_bclk); t1 = $time;
    chk("R11 bit clock period ns", 64'(t1 - t0), 20);
    tdm_grab(f, fsb, -1, 0, '0);
    for (int s = 0; s < 8; s++)
      chk("R8 slot", f[511 - 32*s -: 32], tdm_exp(v)[255 - 32*s -: 32]);
    chk("R9 frame sync placement", 64'(fsb), 0);
  endtask

  task automatic t_tdm_boundary();
    logic [511:0] f;
    logic [255:0] e0, e1;
    logic [5:0][23:0] v;
    int fsb;
    for (int c = 0; c < 6; c++) begin
      dsp(20 + c, 26'(26'h0010101 * (c + 1)), 1'b1);
      v[c] = sat(26'(26'h0010101 * (c + 1)));
    end
    tdm_grab(f, fsb, -1, 0, '0);   // settle new values into frames
    tdm_grab(f, fsb, 100, 22, 26'h0777777);
    e0 = tdm_exp(v);
    v[2] = 24'h777777;
    e1 = tdm_exp(v);
    chk("R10 old slot 2 in frame", f[511 - 64 -: 32], e0[255 - 64 -: 32]);
    chk("R10 new slot 2 next frame", f[255 - 64 -: 32], e1[255 - 64 -: 32]);
    chk("R9 fs over two frames", 64'(fsb), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stereo();
    t_sat();
    t_nocap();
    t_stereo_boundary();
    t_tdm_off();
    t_tdm();
    t_tdm_boundary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule